// File: doc/BRIEF.md
# Dual-Buffer SPI Write Engine

This block sits behind an SPI slave port and loads bytes into one of two on-chip byte buffers. A transfer begins when chip-select falls. The first byte is a command code, and it chooses which buffer to fill. The next three bytes form a 24-bit start location. After that comes a stream of data bytes of any length. Each complete data byte lands at the current location, and the location then advances by one. After the last location it returns to zero. The stream ends when chip-select rises.

The SPI pins are sampled in the system clock domain, so the serial clock must run well below the system clock. Each buffer has its own asynchronous read port, so its contents can be inspected at any time.

Top module: `spi_dual_buf_wr`

## Requirements
- R1: Command byte 0x84 directs the following data into buffer 0, and command byte 0x87 directs it into buffer 1. The buffer that was not selected is left unchanged.
- R2: Three bytes follow the command byte and form a 24-bit start field. Only its 11 least significant bits give the start location. The upper 13 bits have no effect.
- R3: Serial bits are taken on each rising edge of spi_sck, most significant bit first. Every complete data byte is written to the current location, and the location then advances by one.
- R4: A data byte written at location DEPTH-1 (1055 by default) is followed by a byte written at location 0.
- R5: A start location at or above DEPTH is reduced modulo DEPTH, so start 2000 maps to location 944.
- R6: A data byte with fewer than 8 bits when chip-select rises is discarded. The next transfer starts again by expecting a command byte.
- R7: A first byte other than 0x84 or 0x87 makes the rest of the transfer, up to the rise of chip-select, have no effect on either buffer.
- R8: After reset, every location of both buffers reads as zero.
- R9: A new write command does not clear a buffer. Locations the new command does not write keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock; bits are taken on its rising edge |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | SPI serial data into the block |
| rd0_addr | input | PTR_W (11) | Read location for buffer 0 |
| rd0_data | output | 8 | Contents of buffer 0 at rd0_addr |
| rd1_addr | input | PTR_W (11) | Read location for buffer 1 |
| rd1_data | output | 8 | Contents of buffer 1 at rd1_addr |

## Verification
Two functions can act in the same cycle: committing a data byte at location DEPTH-1 and returning the write location to zero. In that cycle the last location is written and the pointer wraps at once. The bench provokes this by starting a stream two locations before the end and sending four bytes. It judges the result by reading locations 1054, 1055, 0 and 1 through the read port. The rise of chip-select also coincides with byte assembly. This is provoked by ending a transfer five bits into a byte, and it is judged by confirming that the location that byte would have filled still holds zero.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
    typedef enum logic [2:0] {
        ST_CMD,
        ST_AD0,
        ST_AD1,
        ST_AD2,
        ST_DATA,
        ST_SKIP
    } dbw_st_e;

    localparam logic [7:0] CMD_FILL0 = 8'h84;
    localparam logic [7:0] CMD_FILL1 = 8'h87;
endpackage

// File: rtl/dbw_pin_sync.sv
module dbw_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic bit_stb,
    output logic bit_val,
    output logic cs_idle
);
    typedef struct packed {
        logic sck;
        logic sck_prev;
        logic cs;
        logic mosi;
    } pin_t;

    pin_t q, d;

    always_comb begin
        d          = q;
        d.sck      = sck;
        d.sck_prev = q.sck;
        d.cs       = cs_n;
        d.mosi     = mosi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sck: 1'b0, sck_prev: 1'b0, cs: 1'b1, mosi: 1'b0};
        else        q <= d;
    end

    assign bit_stb = q.sck & ~q.sck_prev & ~q.cs;
    assign bit_val = q.mosi;
    assign cs_idle = q.cs;

    // R3: a strobe marks a single rising edge, never two in a row
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);
endmodule

// File: rtl/dbw_cmd.sv
module dbw_cmd
    import dbw_pkg::*;
#(
    parameter int DEPTH     = 1056,
    parameter int ADDR_BITS = 11,
    parameter int PTR_W     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             cs_idle,
    output logic             wr_en,
    output logic             wr_sel,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [7:0]       wr_byte
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        dbw_st_e              st;
        logic [7:0]           sh;
        logic [2:0]           cnt;
        logic                 sel;
        logic [ADDR_BITS-1:0] addr;
        logic [PTR_W-1:0]     ptr;
        logic                 we;
        logic                 wsel;
        logic [PTR_W-1:0]     wptr;
        logic [7:0]           wbyte;
    } cmd_t;

    cmd_t q, d;
    logic [7:0]           next_byte;
    logic [ADDR_BITS-1:0] next_addr;

    function automatic logic [PTR_W-1:0] fold(input logic [ADDR_BITS-1:0] a);
        return PTR_W'(int'(a) % DEPTH);
    endfunction

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        next_byte = {q.sh[6:0], bit_val};
        next_addr = {q.addr[ADDR_BITS-2:0], bit_val};
        if (cs_idle) begin
            d.st  = ST_CMD;
            d.cnt = '0;
        end else if (bit_stb) begin
            d.sh  = next_byte;
            d.cnt = q.cnt + 3'd1;
            if (q.st == ST_AD0 || q.st == ST_AD1 || q.st == ST_AD2)
                d.addr = next_addr;
            if (q.cnt == 3'd7) begin
                unique case (q.st)
                    ST_CMD: begin
                        if (next_byte == CMD_FILL0) begin
                            d.st  = ST_AD0;
                            d.sel = 1'b0;
                        end else if (next_byte == CMD_FILL1) begin
                            d.st  = ST_AD0;
                            d.sel = 1'b1;
                        end else begin
                            d.st  = ST_SKIP;
                        end
                    end
                    ST_AD0: d.st = ST_AD1;
                    ST_AD1: d.st = ST_AD2;
                    ST_AD2: begin
                        d.st  = ST_DATA;
                        d.ptr = fold(next_addr);
                    end
                    ST_DATA: begin
                        d.we    = 1'b1;
                        d.wsel  = q.sel;
                        d.wptr  = q.ptr;
                        d.wbyte = next_byte;
                        d.ptr   = (q.ptr == LAST) ? '0 : q.ptr + 1'b1;
                    end
                    default: d.st = ST_SKIP;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_CMD, default: '0};
        else        q <= d;
    end

    assign wr_en   = q.we;
    assign wr_sel  = q.wsel;
    assign wr_ptr  = q.wptr;
    assign wr_byte = q.wbyte;

    // R3: a write only follows a sampled serial bit
    p_write_after_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(bit_stb));
    // R6: chip-select high blocks any write in the next cycle
    p_no_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !wr_en);
    // R7: an unknown command never leads to a write
    p_skip_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP) |=> !wr_en);
    // R4: a byte written at the last location is followed by a pointer of zero
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == LAST && q.st == ST_DATA) |-> (q.ptr == '0));
endmodule

// File: rtl/dbw_bank.sv
module dbw_bank #(
    parameter int DEPTH = 1056,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem_q[raddr] : 8'h00;

    // R4/R5: every write lands inside the buffer
    p_waddr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/spi_dual_buf_wr.sv
module spi_dual_buf_wr #(
    parameter int DEPTH     = 1056,
    parameter int ADDR_BITS = 11,
    parameter int PTR_W     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sck,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    input  logic [PTR_W-1:0] rd0_addr,
    output logic [7:0]       rd0_data,
    input  logic [PTR_W-1:0] rd1_addr,
    output logic [7:0]       rd1_data
);
    localparam int NBUF = 2;

    logic             bit_stb, bit_val, cs_idle;
    logic             wr_en, wr_sel;
    logic [PTR_W-1:0] wr_ptr;
    logic [7:0]       wr_byte;
    logic [PTR_W-1:0] raddr [NBUF];
    logic [7:0]       rdata [NBUF];
    logic [NBUF-1:0]  bank_we;

    dbw_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .bit_stb(bit_stb), .bit_val(bit_val), .cs_idle(cs_idle)
    );

    dbw_cmd #(.DEPTH(DEPTH), .ADDR_BITS(ADDR_BITS), .PTR_W(PTR_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .cs_idle(cs_idle), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ptr(wr_ptr),
        .wr_byte(wr_byte)
    );

    assign raddr[0] = rd0_addr;
    assign raddr[1] = rd1_addr;
    assign rd0_data = rdata[0];
    assign rd1_data = rdata[1];

    for (genvar g = 0; g < NBUF; g++) begin : g_bank
        assign bank_we[g] = wr_en && (int'(wr_sel) == g);
        dbw_bank #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_bank (
            .clk(clk), .rst_n(rst_n), .we(bank_we[g]), .waddr(wr_ptr),
            .wdata(wr_byte), .raddr(raddr[g]), .rdata(rdata[g])
        );
    end

    // R1: at most one buffer is written per cycle
    p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));
endmodule

// File: tb/spi_dual_buf_wr_tb.sv
module spi_dual_buf_wr_tb;
    localparam int DEPTH = 1056;
    localparam int PW    = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [PW-1:0] rd0_addr = '0, rd1_addr = '0;
    logic [7:0]    rd0_data, rd1_data;
    int            checks = 0, failures = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    spi_dual_buf_wr u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd1_addr(rd1_addr), .rd1_data(rd1_data)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b);
        mosi = b;
        wait_clk(4);
        sck = 1'b1;
        wait_clk(4);
        sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) spi_bit(b[i]);
    endtask

    task automatic cs_start();
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic cs_end();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic write_cmd(input logic [7:0] cmd, input logic [23:0] start);
        cs_start();
        spi_byte(cmd);
        spi_byte(start[23:16]);
        spi_byte(start[15:8]);
        spi_byte(start[7:0]);
    endtask

    task automatic chk(input int bank, input int addr, input logic [7:0] exp, input string tag);
        logic [7:0] got;
        @(negedge clk);
        if (bank == 0) rd0_addr = PW'(addr);
        else           rd1_addr = PW'(addr);
        #1;
        got = (bank == 0) ? rd0_data : rd1_data;
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s buf%0d[%0d] actual=%02h expected=%02h", tag, bank, addr, got, exp);
        end
    endtask

    task automatic t_reset();     // R8
        chk(0, 0, 8'h00, "R8");
        chk(1, DEPTH - 1, 8'h00, "R8");
        chk(0, 500, 8'h00, "R8");
    endtask

    task automatic t_fill0();     // R1, R3
        write_cmd(8'h84, 24'h000010);
        spi_byte(8'hA1); spi_byte(8'hB2); spi_byte(8'hC3); spi_byte(8'h3C);
        cs_end();
        chk(0, 16, 8'hA1, "R3");
        chk(0, 17, 8'hB2, "R3");
        chk(0, 18, 8'hC3, "R3");
        chk(0, 19, 8'h3C, "R3");
        chk(1, 16, 8'h00, "R1");
    endtask

    task automatic t_fill1();     // R1, R2
        write_cmd(8'h87, 24'hFFF805);
        spi_byte(8'h5E); spi_byte(8'h77);
        cs_end();
        chk(1, 5, 8'h5E, "R2");
        chk(1, 6, 8'h77, "R1");
        chk(0, 5, 8'h00, "R1");
    endtask

    task automatic t_wrap();      // R4
        write_cmd(8'h84, 24'h00041E);
        spi_byte(8'h11); spi_byte(8'h22); spi_byte(8'h33); spi_byte(8'h44);
        cs_end();
        chk(0, 1054, 8'h11, "R4");
        chk(0, 1055, 8'h22, "R4");
        chk(0, 0,    8'h33, "R4");
        chk(0, 1,    8'h44, "R4");
    endtask

    task automatic t_fold();      // R5
        write_cmd(8'h87, 24'h0007D0);
        spi_byte(8'h9D);
        cs_end();
        chk(1, 944, 8'h9D, "R5");
    endtask

    task automatic t_partial();   // R6
        write_cmd(8'h84, 24'h000064);
        spi_byte(8'h5A);
        for (int i = 0; i < 5; i++) spi_bit(1'b1);
        cs_end();
        chk(0, 100, 8'h5A, "R6");
        chk(0, 101, 8'h00, "R6");
        write_cmd(8'h84, 24'h0000C8);
        spi_byte(8'h6B);
        cs_end();
        chk(0, 200, 8'h6B, "R6");
    endtask

    task automatic t_skip();      // R7
        cs_start();
        spi_byte(8'h03);
        spi_byte(8'h84); spi_byte(8'h00); spi_byte(8'h00); spi_byte(8'h20);
        spi_byte(8'hEE); spi_byte(8'hEE);
        cs_end();
        chk(0, 32, 8'h00, "R7");
        chk(1, 32, 8'h00, "R7");
        chk(0, 33, 8'h00, "R7");
    endtask

    task automatic t_retain();    // R9
        write_cmd(8'h84, 24'h000011);
        spi_byte(8'hF0);
        cs_end();
        chk(0, 17, 8'hF0, "R9");
        chk(0, 16, 8'hA1, "R9");
        chk(0, 18, 8'hC3, "R9");
        chk(1, 5,  8'h5E, "R9");
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_fill0();
        t_fill1();
        t_wrap();
        t_fold();
        t_partial();
        t_skip();
        t_retain();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule